// File: doc/BRIEF.md
# Subtract-Compare Status Flag Unit

This block holds an 8-bit processor status register and updates it from subtract-compare operations. There are three compare forms: register against register, register against an immediate, and register against register with an incoming borrow. For each form the unit forms the 8-bit difference of the two operands. From the operands and the result it derives the carry, half-carry, overflow, negative, sign and zero flags, using bitwise borrow and overflow equations. The difference is purely combinational. The flags are written on the clock edge after the compare is accepted.

The same register also takes three other kinds of update: single-bit set and clear commands, and an overwrite of the whole register. The overwrite models a write to the status location in I/O space. A combinational branch evaluator reads a 16-bit conditional-branch word. It reports whether the branch is taken against the present flags, and gives the word's 7-bit offset sign-extended to the output width.

Compares enter through a valid/ready pair. A compare counts as accepted only in a cycle where both `cmp_valid` and `cmp_ready` are high. `cmp_ready` drops while a whole-register write is requested, because that write takes priority. A held compare must keep its operands and its kind stable until it is accepted. The flag commands, the register write and the branch inputs are plain control pins.

Top module: `status_cmp_unit`

## Requirements
- R1: `diff` equals `op_a - op_b` modulo 256 in the same cycle. When `cmp_kind` is 2'b10 (compare with borrow) and status bit 0 (carry) is set, a further 1 is subtracted. Kinds 2'b00 (register), 2'b01 (immediate) and 2'b11 (treated as register) ignore the carry.
- R2: After an accepted compare, carry (bit 0) is bit 7 of `(~A & B) | (B & D) | (D & ~A)`, and half-carry (bit 5) is bit 3 of the same expression. Here A is `op_a`, B is `op_b` and D is `diff`.
- R3: After an accepted compare, overflow (bit 3) is bit 7 of `(A & ~B & ~D) | (~A & B & D)`. Negative (bit 2) is D[7]. Sign (bit 4) is negative XOR overflow.
- R4: For kinds other than 2'b10, zero (bit 1) is set exactly when D is 0x00.
- R5: For kind 2'b10, zero becomes (D == 0x00) AND the previous zero bit. This form can clear zero but never set it.
- R6: A compare changes status only on the clock edge after acceptance. Bits 7 and 6 are left unchanged.
- R7: When `flag_cmd_en` is high, the status bit chosen by `flag_cmd_idx` is set (`flag_cmd_set`=1) or cleared (`flag_cmd_set`=0). All other bits keep their values.
- R8: `sreg_wr_en` loads `sreg_wr_data` into the whole register on the next edge. It overrides everything else, and `cmp_ready` is low in that cycle.
- R9: When a compare is accepted in the same cycle as a flag command, the compare result is written and the flag command is ignored.
- R10: `br_taken` is high when the status bit selected by `br_word[2:0]` equals `br_word[10]`.
- R11: `br_offset` is `br_word[9:3]` sign-extended from bit 9.
- R12: After reset, status is 0x00.
- R13: In a cycle with no write, no accepted compare and no flag command, status holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Compare request valid |
| cmp_ready | output | 1 | Compare can be accepted this cycle |
| cmp_kind | input | 2 | 00 register, 01 immediate, 10 with borrow, 11 as register |
| op_a | input | 8 | Minuend |
| op_b | input | 8 | Subtrahend (register value or immediate) |
| diff | output | 8 | Combinational difference |
| flag_cmd_en | input | 1 | Single-flag command strobe |
| flag_cmd_set | input | 1 | 1 sets, 0 clears the selected bit |
| flag_cmd_idx | input | 3 | Status bit index |
| sreg_wr_en | input | 1 | Whole-register write strobe |
| sreg_wr_data | input | 8 | Value for whole-register write |
| br_word | input | 16 | Conditional-branch word |
| br_taken | output | 1 | Branch condition met |
| br_offset | output | BR_OFS_W | Sign-extended branch offset |
| status | output | 8 | Status register |

## Verification
Two pairs of updates can land in the same cycle. A compare can meet a single-flag command, and a compare can meet a whole-register write. The bench raises both strobes in one cycle and then reads `status` on the next falling edge. With a flag command, it expects exactly the compare flags and no trace of the flag command. With a register write, it expects exactly the written value, and it checks that `cmp_ready` was low during that cycle. It then sends the compare again alone to show that the compare was not lost but refused.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  localparam int DW = 8;
  localparam int BIT_C = 0;
  localparam int BIT_Z = 1;
  localparam int BIT_N = 2;
  localparam int BIT_V = 3;
  localparam int BIT_S = 4;
  localparam int BIT_H = 5;
  localparam int CMP_FLAGS = 6;

  typedef enum logic [1:0] {
    KIND_REG    = 2'b00,
    KIND_IMM    = 2'b01,
    KIND_BORROW = 2'b10,
    KIND_ALT    = 2'b11
  } cmp_kind_e;

  typedef struct packed {
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } cmp_flags_t;
endpackage

// File: rtl/sfu_sub_flags.sv
module sfu_sub_flags
  import sfu_pkg::*;
#(
  parameter int W = DW,
  parameter int HALF_BIT = 3
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         borrow_form,
  input  logic         carry_in,
  input  logic         zero_in,
  output logic [W-1:0] res,
  output cmp_flags_t   flags
);
  localparam int MSB = W - 1;

  logic [W-1:0] brw;
  logic [W-1:0] ovf;
  logic         extra;

  always_comb begin
    extra = borrow_form & carry_in;
    res   = a - b - {{(W-1){1'b0}}, extra};
    brw   = (~a & b) | (b & res) | (res & ~a);
    ovf   = (a & ~b & ~res) | (~a & b & res);
    flags.c = brw[MSB];
    flags.h = brw[HALF_BIT];
    flags.v = ovf[MSB];
    flags.n = res[MSB];
    flags.s = res[MSB] ^ ovf[MSB];
    flags.z = borrow_form ? ((res == '0) & zero_in) : (res == '0);
  end
endmodule

// File: rtl/sfu_status_reg.sv
module sfu_status_reg
  import sfu_pkg::*;
#(
  parameter int W = DW,
  parameter int NFLAG = CMP_FLAGS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [W-1:0]         wr_data,
  input  logic                 cmp_load,
  input  logic [NFLAG-1:0]     cmp_bits,
  input  logic                 cmd_en,
  input  logic                 cmd_set,
  input  logic [$clog2(W)-1:0] cmd_idx,
  output logic [W-1:0]         q
);
  logic [W-1:0] nxt;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic hit;
    assign hit = cmd_en && (cmd_idx == i[$clog2(W)-1:0]);
    if (i < NFLAG) begin : g_cmp
      always_comb begin
        if (wr_en)         nxt[i] = wr_data[i];
        else if (cmp_load) nxt[i] = cmp_bits[i];
        else if (hit)      nxt[i] = cmd_set;
        else               nxt[i] = q[i];
      end
    end else begin : g_keep
      always_comb begin
        if (wr_en)         nxt[i] = wr_data[i];
        else if (cmp_load) nxt[i] = q[i];
        else if (hit)      nxt[i] = cmd_set;
        else               nxt[i] = q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/sfu_branch_eval.sv
module sfu_branch_eval
  import sfu_pkg::*;
#(
  parameter int W = DW,
  parameter int OFS_W = 8
) (
  input  logic [15:0]      word,
  input  logic [W-1:0]     flags,
  output logic             taken,
  output logic [OFS_W-1:0] offset
);
  localparam int RAW_W = 7;
  localparam int EXT_W = OFS_W - RAW_W;

  logic [RAW_W-1:0] raw;
  logic             sel;

  assign raw    = word[9:3];
  assign sel    = flags[word[2:0]];
  assign taken  = (sel == word[10]);
  assign offset = {{EXT_W{raw[RAW_W-1]}}, raw};
endmodule

// File: rtl/status_cmp_unit.sv
module status_cmp_unit
  import sfu_pkg::*;
#(
  parameter int BR_OFS_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmp_valid,
  output logic                cmp_ready,
  input  logic [1:0]          cmp_kind,
  input  logic [7:0]          op_a,
  input  logic [7:0]          op_b,
  output logic [7:0]          diff,
  input  logic                flag_cmd_en,
  input  logic                flag_cmd_set,
  input  logic [2:0]          flag_cmd_idx,
  input  logic                sreg_wr_en,
  input  logic [7:0]          sreg_wr_data,
  input  logic [15:0]         br_word,
  output logic                br_taken,
  output logic [BR_OFS_W-1:0] br_offset,
  output logic [7:0]          status
);
  cmp_flags_t           fl;
  logic                 accept;
  logic                 borrow_form;
  logic [CMP_FLAGS-1:0] fl_bits;

  assign cmp_ready   = ~sreg_wr_en;
  assign accept      = cmp_valid & cmp_ready;
  assign borrow_form = (cmp_kind == KIND_BORROW);

  sfu_sub_flags #(.W(DW), .HALF_BIT(3)) u_sub (
    .a(op_a), .b(op_b), .borrow_form(borrow_form),
    .carry_in(status[BIT_C]), .zero_in(status[BIT_Z]),
    .res(diff), .flags(fl)
  );

  always_comb begin
    fl_bits        = '0;
    fl_bits[BIT_C] = fl.c;
    fl_bits[BIT_Z] = fl.z;
    fl_bits[BIT_N] = fl.n;
    fl_bits[BIT_V] = fl.v;
    fl_bits[BIT_S] = fl.s;
    fl_bits[BIT_H] = fl.h;
  end

  sfu_status_reg #(.W(DW), .NFLAG(CMP_FLAGS)) u_sreg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(sreg_wr_en), .wr_data(sreg_wr_data),
    .cmp_load(accept), .cmp_bits(fl_bits),
    .cmd_en(flag_cmd_en), .cmd_set(flag_cmd_set), .cmd_idx(flag_cmd_idx),
    .q(status)
  );

  sfu_branch_eval #(.W(DW), .OFS_W(BR_OFS_W)) u_br (
    .word(br_word), .flags(status),
    .taken(br_taken), .offset(br_offset)
  );
endmodule

// File: rtl/status_cmp_unit_chk.sv
module status_cmp_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmp_valid,
  input logic        cmp_ready,
  input logic [1:0]  cmp_kind,
  input logic        flag_cmd_en,
  input logic        flag_cmd_set,
  input logic [2:0]  flag_cmd_idx,
  input logic        sreg_wr_en,
  input logic [7:0]  sreg_wr_data,
  input logic [15:0] br_word,
  input logic        br_taken,
  input logic [7:0]  br_offset,
  input logic [7:0]  status
);
  logic acc;
  assign acc = cmp_valid & cmp_ready;

  assert_sign_xor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (status[4] == (status[2] ^ status[3])));

  assert_keep_ti_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !sreg_wr_en) |=> (status[7:6] == $past(status[7:6])));

  assert_zero_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmp_kind == 2'b10 && !status[1]) |=> !status[1]);

  assert_full_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sreg_wr_en |=> (status == $past(sreg_wr_data)));

  assert_single_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_cmd_en && !acc && !sreg_wr_en) |=>
      (((status ^ $past(status)) & ~(8'h01 << $past(flag_cmd_idx))) == 8'h00 &&
       status[$past(flag_cmd_idx)] == $past(flag_cmd_set)));

  assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_cmd_en && !cmp_valid && !sreg_wr_en) |=> $stable(status));

  always_comb begin
    if (rst_n) begin
      assert_branch_R10: assert (br_taken == (status[br_word[2:0]] == br_word[10]));
      assert_offset_sign_R11: assert (br_offset[7] == br_word[9]);
    end
  end
endmodule

bind status_cmp_unit status_cmp_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_ready(cmp_ready),
  .cmp_kind(cmp_kind), .flag_cmd_en(flag_cmd_en), .flag_cmd_set(flag_cmd_set),
  .flag_cmd_idx(flag_cmd_idx), .sreg_wr_en(sreg_wr_en), .sreg_wr_data(sreg_wr_data),
  .br_word(br_word), .br_taken(br_taken), .br_offset(br_offset[7:0]), .status(status)
);

// File: tb/sim_status_cmp_unit.sv
module sim_status_cmp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_valid = 1'b0;
  logic        cmp_ready;
  logic [1:0]  cmp_kind = 2'b00;
  logic [7:0]  op_a = '0, op_b = '0, diff;
  logic        flag_cmd_en = 1'b0, flag_cmd_set = 1'b0;
  logic [2:0]  flag_cmd_idx = '0;
  logic        sreg_wr_en = 1'b0;
  logic [7:0]  sreg_wr_data = '0;
  logic [15:0] br_word = '0;
  logic        br_taken;
  logic [7:0]  br_offset;
  logic [7:0]  status;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  status_cmp_unit #(.BR_OFS_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_ready(cmp_ready),
    .cmp_kind(cmp_kind), .op_a(op_a), .op_b(op_b), .diff(diff),
    .flag_cmd_en(flag_cmd_en), .flag_cmd_set(flag_cmd_set), .flag_cmd_idx(flag_cmd_idx),
    .sreg_wr_en(sreg_wr_en), .sreg_wr_data(sreg_wr_data),
    .br_word(br_word), .br_taken(br_taken), .br_offset(br_offset), .status(status)
  );

  // {pre_status, kind, a, b, exp_diff, exp_status}
  localparam int NV = 10;
  localparam logic [41:0] VEC [NV] = '{
    {8'h00, 2'b00, 8'h05, 8'h05, 8'h00, 8'h02},
    {8'h00, 2'b00, 8'h00, 8'h01, 8'hFF, 8'h35},
    {8'h00, 2'b01, 8'h80, 8'h01, 8'h7F, 8'h38},
    {8'h00, 2'b00, 8'h7F, 8'hFF, 8'h80, 8'h0D},
    {8'h01, 2'b10, 8'h10, 8'h0F, 8'h00, 8'h20},
    {8'h03, 2'b10, 8'h01, 8'h00, 8'h00, 8'h02},
    {8'h03, 2'b10, 8'h00, 8'h00, 8'hFF, 8'h35},
    {8'hC0, 2'b00, 8'h05, 8'h05, 8'h00, 8'hC2},
    {8'h02, 2'b10, 8'h03, 8'h03, 8'h00, 8'h02},
    {8'h01, 2'b00, 8'h03, 8'h03, 8'h00, 8'h02}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_sreg(input logic [7:0] v);
    sreg_wr_en = 1'b1; sreg_wr_data = v;
    @(negedge clk);
    sreg_wr_en = 1'b0;
  endtask

  task automatic flag_cmd(input logic [2:0] idx, input logic s);
    flag_cmd_en = 1'b1; flag_cmd_idx = idx; flag_cmd_set = s;
    @(negedge clk);
    flag_cmd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset status", {8'h0, status}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R13 idle hold", {8'h0, status}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      write_sreg(VEC[i][41:34]);
      cmp_kind = VEC[i][33:32]; op_a = VEC[i][31:24]; op_b = VEC[i][23:16];
      cmp_valid = 1'b1;
      #1;
      check($sformatf("R1 diff vec%0d", i), {8'h0, diff}, {8'h0, VEC[i][15:8]});
      check($sformatf("R6 no early update vec%0d", i), {8'h0, status}, {8'h0, VEC[i][41:34]});
      @(negedge clk);
      cmp_valid = 1'b0;
      check($sformatf("R2 R3 R4 R5 flags vec%0d", i), {8'h0, status}, {8'h0, VEC[i][7:0]});
    end

    // R7 set/clear single bit
    write_sreg(8'h00);
    flag_cmd(3'd6, 1'b1);
    check("R7 set bit6", {8'h0, status}, 16'h0040);
    flag_cmd(3'd0, 1'b1);
    check("R7 set bit0", {8'h0, status}, 16'h0041);
    flag_cmd(3'd6, 1'b0);
    check("R7 clear bit6", {8'h0, status}, 16'h0001);
    @(negedge clk);
    check("R13 hold", {8'h0, status}, 16'h0001);

    // R9 compare with flag command in same cycle
    write_sreg(8'h00);
    cmp_kind = 2'b00; op_a = 8'h05; op_b = 8'h05; cmp_valid = 1'b1;
    flag_cmd_en = 1'b1; flag_cmd_idx = 3'd7; flag_cmd_set = 1'b1;
    @(negedge clk);
    cmp_valid = 1'b0; flag_cmd_en = 1'b0;
    check("R9 compare wins over flag cmd", {8'h0, status}, 16'h0002);

    // R8 write collides with compare
    cmp_kind = 2'b00; op_a = 8'h00; op_b = 8'h01; cmp_valid = 1'b1;
    sreg_wr_en = 1'b1; sreg_wr_data = 8'hA4;
    #1;
    check("R8 ready low during write", {15'h0, cmp_ready}, 16'h0000);
    @(negedge clk);
    sreg_wr_en = 1'b0;
    check("R8 write wins", {8'h0, status}, 16'h00A4);
    #1;
    check("R8 ready back", {15'h0, cmp_ready}, 16'h0001);
    @(negedge clk);
    cmp_valid = 1'b0;
    check("R8 held compare accepted later", {8'h0, status}, 16'h00B5);

    // R10 R11 branch
    write_sreg(8'h02);
    br_word = 16'h07F9; #1;
    check("R10 taken Z=1 want 1", {15'h0, br_taken}, 16'h0001);
    check("R11 offset -1", {8'h0, br_offset}, 16'h00FF);
    br_word = 16'h03F9; #1;
    check("R10 not taken Z=1 want 0", {15'h0, br_taken}, 16'h0000);
    br_word = 16'h0429; #1;
    check("R11 offset +5", {8'h0, br_offset}, 16'h0005);
    br_word = 16'h0028; #1;
    check("R10 C=0 want 0 taken", {15'h0, br_taken}, 16'h0001);

    // R12 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R12 reset clears", {8'h0, status}, 16'h0000);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule